// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches the single tearing-effect pin that a display panel drives and sorts each pulse on it into a horizontal or a vertical sync by its width. Widths are measured in ticks of a slow timebase, which is the block clock divided by a programmable factor of 1 to 8. A narrow threshold separates horizontal sync from noise, and a coarse wide threshold in steps of 8 ticks separates vertical sync from horizontal sync. Each of the two detection paths has its own polarity inversion.

A line counter clears on every vertical sync and advances on every horizontal sync. Depending on the mode, the block signals a match either on every vertical sync or when the line count reaches a programmed target. The match is an active-low pulse one tick long, and its falling edge is meant to start a waiting frame transfer.

Top module: `te_sync_detect`

## Requirements
- R1: The tick lasts `cfg_div`+1 clock cycles. The pin is sampled once per tick, and a pulse's width is the number of ticks in which the pulse was seen active.
- R2: The horizontal threshold is `cfg_hs_width`+1 ticks. A pulse at least this wide but narrower than the vertical threshold is a horizontal sync. A narrower pulse is ignored.
- R3: The vertical threshold is (`cfg_vs_width`+1)*8 ticks. A pulse at least this wide is a vertical sync.
- R4: When `cfg_hs_inv` is 1, the horizontal path treats low phases of the pin as pulses. `cfg_vs_inv` does the same for the vertical path. With both bits set, low pulses are classified just as high pulses are classified with both bits clear.
- R5: Mode codes 0 and 1 in `cfg_mode` never produce a match.
- R6: In mode code 3, every vertical sync produces one match. Horizontal syncs produce none.
- R7: In mode code 2, a vertical sync sets the line count to 0 and each horizontal sync adds one. A match fires when the count after the event equals `cfg_line`, so a target of 0 matches on the vertical sync itself.
- R8: `match_n` stays high when idle. A match drives it low for exactly one tick (`cfg_div`+1 clocks), after which it returns high.
- R9: After reset, `match_n` is high and no match is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_in | input | 1 | Tearing-effect pin from the panel (asynchronous) |
| cfg_div | input | 3 | Tick divider, ticks are cfg_div+1 clocks |
| cfg_hs_width | input | 3 | Horizontal width threshold, ticks minus one |
| cfg_vs_width | input | 9 | Vertical width threshold, units of 8 ticks minus one |
| cfg_hs_inv | input | 1 | Invert horizontal detection polarity |
| cfg_vs_inv | input | 1 | Invert vertical detection polarity |
| cfg_mode | input | 2 | 0/1 off, 2 line match, 3 vertical sync match |
| cfg_line | input | 11 | Target line for mode 2 |
| match_n | output | 1 | Active-low match pulse |

## Verification
In one tick, the line counter can update and the match decision can be taken from the value that update produces. A vertical sync with target 0 has to match on the cleared count. A horizontal sync has to compare the count after its increment, not the stale one. The bench provokes this by running one vertical sync followed by a single pulse of every width from 1 to 20 ticks, with target 1, for several horizontal thresholds. A match is expected exactly when the width falls in the horizontal band. It also counts matches across a burst of horizontal syncs with target 5, and checks that target 0 matches only on the vertical sync.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
   typedef enum logic [1:0] {
      TE_MODE_OFF   = 2'd0,
      TE_MODE_RSVD  = 2'd1,
      TE_MODE_LINE  = 2'd2,
      TE_MODE_VSYNC = 2'd3
   } te_mode_e;

   localparam int unsigned TE_VS_UNIT_SHIFT = 3;
endpackage

// File: rtl/te_tick_gen.sv
module te_tick_gen #(
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             tick_en
);
   logic [DIV_W-1:0] div_cnt;

   assign tick_en = (div_cnt >= cfg_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_cnt <= '0;
      else if (tick_en) div_cnt <= '0;
      else              div_cnt <= div_cnt + 1'b1;
   end

   // R1: a tick with a divider above one is followed by a quiet cycle
   p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cfg_div != '0) |=> (!tick_en || cfg_div == '0));
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             lvl,
   output logic             end_stb,
   output logic [CNT_W-1:0] width
);
   logic [CNT_W-1:0] run_cnt;

   assign end_stb = tick_en && !lvl && (run_cnt != '0);
   assign width   = run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (tick_en) begin
         if (!lvl)                run_cnt <= '0;
         else if (run_cnt != '1)  run_cnt <= run_cnt + 1'b1;
      end
   end

   // R1: once a pulse has been reported the width measurement restarts
   p_width_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      end_stb |=> (run_cnt == '0));

   // R1: width never moves between ticks
   p_width_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(run_cnt));
endmodule

// File: rtl/te_line_match.sv
module te_line_match
   import te_sync_pkg::*;
#(
   parameter int unsigned LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              vs_evt,
   input  logic              hs_evt,
   input  te_mode_e          mode,
   input  logic [LINE_W-1:0] target,
   output logic              match_n
);
   logic [LINE_W-1:0] line_cnt;
   logic [LINE_W-1:0] line_nxt;
   logic              hit;

   always_comb begin
      line_nxt = line_cnt;
      if (vs_evt)                         line_nxt = '0;
      else if (hs_evt && line_cnt != '1)  line_nxt = line_cnt + 1'b1;
   end

   always_comb begin
      unique case (mode)
         TE_MODE_VSYNC: hit = vs_evt;
         TE_MODE_LINE:  hit = (vs_evt || hs_evt) && (line_nxt == target);
         default:       hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         match_n  <= 1'b1;
      end else begin
         line_cnt <= line_nxt;
         if (hit)          match_n <= 1'b0;
         else if (tick_en) match_n <= 1'b1;
      end
   end

   // R7: vertical sync leaves the line counter at zero
   p_line_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vs_evt |=> (line_cnt == '0));

   // R7: a lone horizontal sync advances the count by one
   p_line_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_evt && !vs_evt && line_cnt != '1) |=> (line_cnt == $past(line_cnt) + 1'b1));

   // R8: a low match pulse persists until the next tick
   p_match_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!match_n && !tick_en) |=> !match_n);

   // R5: disabled modes release the output at every tick
   p_mode_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && (mode == TE_MODE_OFF || mode == TE_MODE_RSVD)) |=> match_n);
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
   import te_sync_pkg::*;
#(
   parameter int unsigned DIV_W       = 3,
   parameter int unsigned HS_W        = 3,
   parameter int unsigned VS_W        = 9,
   parameter int unsigned LINE_W      = 11,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              te_in,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [HS_W-1:0]   cfg_hs_width,
   input  logic [VS_W-1:0]   cfg_vs_width,
   input  logic              cfg_hs_inv,
   input  logic              cfg_vs_inv,
   input  logic [1:0]        cfg_mode,
   input  logic [LINE_W-1:0] cfg_line,
   output logic              match_n
);
   localparam int unsigned CNT_W   = VS_W + TE_VS_UNIT_SHIFT + 1;
   localparam int unsigned N_PATHS = 2;
   localparam int unsigned P_HS    = 0;
   localparam int unsigned P_VS    = 1;

   initial begin : p_param_chk
      assert (SYNC_STAGES >= 2) else $error("te_sync_detect: SYNC_STAGES below 2");
      assert (HS_W <= VS_W + TE_VS_UNIT_SHIFT) else $error("te_sync_detect: HS_W too wide");
      assert (DIV_W >= 1 && LINE_W >= 1) else $error("te_sync_detect: zero width field");
   end

   logic             tick_en;
   logic [SYNC_STAGES-1:0] te_sync;
   logic             te_s;
   logic [N_PATHS-1:0] path_lvl;
   logic [N_PATHS-1:0] path_end;
   logic [CNT_W-1:0] path_width [N_PATHS];
   logic [CNT_W-1:0] hs_th;
   logic [CNT_W-1:0] vs_th;
   logic             hs_evt;
   logic             vs_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) te_sync <= '0;
      else        te_sync <= {te_sync[SYNC_STAGES-2:0], te_in};
   end
   assign te_s = te_sync[SYNC_STAGES-1];

   te_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_div (cfg_div),
      .tick_en (tick_en)
   );

   assign path_lvl[P_HS] = te_s ^ cfg_hs_inv;
   assign path_lvl[P_VS] = te_s ^ cfg_vs_inv;

   for (genvar gi = 0; gi < N_PATHS; gi++) begin : g_path
      te_pulse_meter #(.CNT_W(CNT_W)) u_meter (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick_en (tick_en),
         .lvl     (path_lvl[gi]),
         .end_stb (path_end[gi]),
         .width   (path_width[gi])
      );
   end

   assign hs_th = CNT_W'(cfg_hs_width) + 1'b1;
   assign vs_th = (CNT_W'(cfg_vs_width) + 1'b1) << TE_VS_UNIT_SHIFT;

   assign vs_evt = path_end[P_VS] && (path_width[P_VS] >= vs_th);
   assign hs_evt = path_end[P_HS] && (path_width[P_HS] >= hs_th)
                                  && (path_width[P_HS] <  vs_th);

   te_line_match #(.LINE_W(LINE_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .vs_evt  (vs_evt),
      .hs_evt  (hs_evt),
      .mode    (te_mode_e'(cfg_mode)),
      .target  (cfg_line),
      .match_n (match_n)
   );

   // R2 R3: one tick never carries both classifications
   p_evt_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(vs_evt && hs_evt));

   // R6: vertical-only mode answers a vertical sync in the next cycle
   p_vsync_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_evt && cfg_mode == 2'd3) |=> !match_n);
endmodule

// File: tb/te_sync_detect_tb.sv
module te_sync_detect_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        te_in = 1'b0;
   logic [2:0]  cfg_div = '0;
   logic [2:0]  cfg_hs_width = '0;
   logic [8:0]  cfg_vs_width = '0;
   logic        cfg_hs_inv = 1'b0;
   logic        cfg_vs_inv = 1'b0;
   logic [1:0]  cfg_mode = '0;
   logic [10:0] cfg_line = '0;
   logic        match_n;

   int checks = 0;
   int fails  = 0;
   int falls  = 0;
   int low_run = 0;
   int last_low = 0;
   logic prev_m = 1'b1;
   logic idle_lvl = 1'b0;
   bit   done = 0;

   always #2 clk = ~clk;

   te_sync_detect u_dut (
      .clk(clk), .rst_n(rst_n), .te_in(te_in), .cfg_div(cfg_div),
      .cfg_hs_width(cfg_hs_width), .cfg_vs_width(cfg_vs_width),
      .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
      .cfg_mode(cfg_mode), .cfg_line(cfg_line), .match_n(match_n)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_m && !match_n) falls++;
         if (!match_n) low_run++;
         else if (low_run != 0) begin last_low = low_run; low_run = 0; end
         prev_m = match_n;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse(int w, int gap);
      @(negedge clk) te_in = ~idle_lvl;
      repeat (w) @(negedge clk);
      te_in = idle_lvl;
      repeat (gap) @(negedge clk);
   endtask

   task automatic set_idle(logic lvl, logic hinv, logic vinv);
      cfg_mode = 2'd0;
      @(negedge clk);
      cfg_hs_inv = hinv; cfg_vs_inv = vinv;
      idle_lvl = lvl; te_in = lvl;
      repeat (80) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int f0;
      int hs_list [3] = '{0, 2, 7};
      repeat (5) @(negedge clk);
      chk("R9 reset level", int'(match_n), 1);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk("R9 idle after reset", int'(match_n), 1);
      chk("R9 no match after reset", falls, 0);

      // R2 R3 R6 sweep with one-clock ticks, vertical threshold 16 ticks
      cfg_div = 3'd0; cfg_vs_width = 9'd1;
      foreach (hs_list[i]) begin
         cfg_hs_width = 3'(hs_list[i]);
         for (int w = 1; w <= 20; w++) begin
            cfg_mode = 2'd3;
            f0 = falls; pulse(w, 30);
            chk($sformatf("R3 R6 mode3 hs=%0d w=%0d", hs_list[i], w),
                falls - f0, (w >= 16) ? 1 : 0);
            cfg_mode = 2'd2; cfg_line = 11'd1;
            pulse(20, 30);
            f0 = falls; pulse(w, 30);
            chk($sformatf("R2 R7 line1 hs=%0d w=%0d", hs_list[i], w),
                falls - f0, (w >= hs_list[i] + 1 && w < 16) ? 1 : 0);
         end
      end
      chk("R8 low width one-clock tick", last_low, 1);

      // R7 counting to line 5
      cfg_hs_width = 3'd1; cfg_mode = 2'd2; cfg_line = 11'd5;
      pulse(20, 30);
      f0 = falls;
      for (int k = 0; k < 4; k++) pulse(4, 10);
      chk("R7 no match before line 5", falls - f0, 0);
      pulse(4, 20);
      chk("R7 match at line 5", falls - f0, 1);
      pulse(4, 10); pulse(4, 20);
      chk("R7 single match per frame", falls - f0, 1);

      // R7 target 0 matches vertical sync only
      cfg_line = 11'd0;
      f0 = falls; pulse(20, 30);
      chk("R7 target 0 on vsync", falls - f0, 1);
      for (int k = 0; k < 3; k++) pulse(4, 10);
      repeat (20) @(negedge clk);
      chk("R7 target 0 ignores hsync", falls - f0, 1);

      // R5 disabled codes
      for (int m = 0; m < 2; m++) begin
         cfg_mode = 2'(m); cfg_line = 11'd0;
         f0 = falls; pulse(20, 30); pulse(4, 30);
         chk($sformatf("R5 mode %0d silent", m), falls - f0, 0);
         chk("R5 output stays high", int'(match_n), 1);
      end

      // R4 both paths inverted, idle high, low pulses
      set_idle(1'b1, 1'b1, 1'b1);
      cfg_mode = 2'd3;
      f0 = falls; pulse(20, 30);
      chk("R4 inverted vsync", falls - f0, 1);
      f0 = falls; pulse(4, 30);
      chk("R4 inverted short ignored by mode3", falls - f0, 0);
      cfg_mode = 2'd2; cfg_line = 11'd1;
      pulse(20, 30);
      f0 = falls; pulse(4, 30);
      chk("R4 inverted hsync line 1", falls - f0, 1);
      set_idle(1'b1, 1'b0, 1'b1);
      cfg_mode = 2'd3;
      f0 = falls; pulse(20, 30);
      chk("R4 vertical path inverted alone", falls - f0, 1);
      set_idle(1'b0, 1'b0, 1'b0);

      // R1 R8 four-clock ticks, vertical threshold 8 ticks
      cfg_div = 3'd3; cfg_vs_width = 9'd0; cfg_hs_width = 3'd0;
      repeat (20) @(negedge clk);
      cfg_mode = 2'd3;
      f0 = falls; pulse(48, 80);
      chk("R1 12-tick pulse is vsync", falls - f0, 1);
      chk("R8 low width four clocks", last_low, 4);
      f0 = falls; pulse(20, 80);
      chk("R1 5-tick pulse not vsync", falls - f0, 0);
      f0 = falls; pulse(40, 80);
      chk("R1 10-tick pulse is vsync", falls - f0, 1);
      f0 = falls; pulse(24, 80);
      chk("R1 6-tick pulse not vsync", falls - f0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule